// File: doc/BRIEF.md
# Non-Restoring Division Step Unit

This block performs a single step of a bit-serial, non-restoring binary division each time it is commanded. It owns a W-bit partial remainder register together with three status flags: a running sign bit Q, a divisor sign bit M and a carry-like flag T that doubles as the quotient bit produced by each step. The divisor is presented on an input port by the surrounding datapath and is not stored.

Software sequences the unit. It loads the partial remainder, issues an unsigned or signed initialise, and then issues one step per quotient bit, typically 32 for a 32-bit divide. Between steps the caller rotates its own quotient/dividend word through T. A write command lets the caller load the remainder and T together. After the last step, one more rotate through T leaves the quotient in the caller's word. Quotient assembly and the register file stay outside the block.

Top module: `divstep_unit`

## Requirements
- R1: Command code 2'b00 (write) loads the remainder register from `wr_rem` and T from `wr_t`, and leaves Q and M unchanged.
- R2: Command code 2'b01 (unsigned initialise) clears Q, M and T to 0 and leaves the remainder unchanged.
- R3: Command code 2'b10 (signed initialise) sets Q to the remainder's top bit, M to the divisor's top bit and T to Q xor M, and leaves the remainder unchanged.
- R4: Command code 2'b11 (step) forms the remainder shifted left by one with the old T in bit 0. It subtracts the divisor from that value when the old Q equals M and adds it otherwise. The remainder takes the W-bit result.
- R5: On a step, the new Q is the bit shifted out of the remainder's top, xor M, xor the carry (add) or borrow (subtract) of the operation, and M stays unchanged.
- R6: After a step, T is 1 exactly when the new Q equals M.
- R7: In a cycle without `cmd_valid`, the remainder, Q, M and T all hold their values.
- R8: After reset, the remainder is 0 and Q, M and T are 0.
- R9: After an unsigned initialise with a zero remainder, 32 rounds of rotating the dividend word through T, each followed by a step, and one final rotate leave the unsigned quotient of dividend by divisor in that word, for any nonzero divisor.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | One-cycle pulse that marks a command |
| cmd | input | 2 | Command code: 00 write, 01 unsigned init, 10 signed init, 11 step |
| wr_rem | input | W | Remainder value loaded by the write command |
| wr_t | input | 1 | T value loaded by the write command |
| divisor | input | W | Divisor operand used by signed initialise and step |
| rem_q | output | W | Current partial remainder |
| q_flag | output | 1 | Current Q flag |
| m_flag | output | 1 | Current M flag |
| t_flag | output | 1 | Current T flag |

## Verification
A single step has two things land on the same clock edge: the bit leaving the top of the remainder and the carry or borrow from the add or subtract. Both feed the new Q, and T follows from it. The bench provokes their overlap with remainders whose top bit is set and with divisors of 0, 1 and all ones, so both terms are active and the arithmetic wraps in either direction. Each result is judged against a bench model that detects carry and borrow by comparing the result with the shifted operand, not from the adder's extra bit. Full 32-step unsigned divides are then compared with the quotient from ordinary integer division.

// File: rtl/divstep_unit.sv
module divstep_unit #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmd_valid,
  input  logic [1:0]   cmd,
  input  logic [W-1:0] wr_rem,
  input  logic         wr_t,
  input  logic [W-1:0] divisor,
  output logic [W-1:0] rem_q,
  output logic         q_flag,
  output logic         m_flag,
  output logic         t_flag
);

  localparam logic [1:0] OP_WR    = 2'b00;
  localparam logic [1:0] OP_INITU = 2'b01;
  localparam logic [1:0] OP_INITS = 2'b10;
  localparam logic [1:0] OP_STEP  = 2'b11;

  logic [W-1:0] shifted;
  logic [W:0]   sum_ext;
  logic [W:0]   dif_ext;
  logic         do_sub;
  logic [W-1:0] step_rem;
  logic         step_cb;
  logic         step_q;

  assign shifted  = {rem_q[W-2:0], t_flag};
  assign do_sub   = (q_flag == m_flag);
  assign sum_ext  = {1'b0, shifted} + {1'b0, divisor};
  assign dif_ext  = {1'b0, shifted} - {1'b0, divisor};
  assign step_rem = do_sub ? dif_ext[W-1:0] : sum_ext[W-1:0];
  assign step_cb  = do_sub ? dif_ext[W] : sum_ext[W];
  assign step_q   = rem_q[W-1] ^ m_flag ^ step_cb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      q_flag <= 1'b0;
      m_flag <= 1'b0;
      t_flag <= 1'b0;
    end else if (cmd_valid) begin
      case (cmd)
        OP_WR: begin
          rem_q  <= wr_rem;
          t_flag <= wr_t;
        end
        OP_INITU: begin
          q_flag <= 1'b0;
          m_flag <= 1'b0;
          t_flag <= 1'b0;
        end
        OP_INITS: begin
          q_flag <= rem_q[W-1];
          m_flag <= divisor[W-1];
          t_flag <= rem_q[W-1] ^ divisor[W-1];
        end
        default: begin
          rem_q  <= step_rem;
          q_flag <= step_q;
          t_flag <= (step_q == m_flag);
        end
      endcase
    end
  end

  assert_write_loads_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd == OP_WR |=> rem_q == $past(wr_rem) && t_flag == $past(wr_t)
      && $stable(q_flag) && $stable(m_flag));

  assert_initu_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd == OP_INITU |=> !q_flag && !m_flag && !t_flag && $stable(rem_q));

  assert_inits_signs_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd == OP_INITS |=> q_flag == $past(rem_q[W-1])
      && m_flag == $past(divisor[W-1]) && $stable(rem_q));

  assert_step_keeps_m_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd == OP_STEP |=> $stable(m_flag));

  assert_t_tracks_qm_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && (cmd == OP_STEP || cmd == OP_INITS) |=> t_flag == (q_flag ^~ m_flag) ^ (cmd == OP_INITS ? 1'b0 : 1'b0) ^ ($past(cmd) == OP_INITS));

  assert_idle_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> $stable(rem_q) && $stable(q_flag) && $stable(m_flag) && $stable(t_flag));

endmodule

// File: tb/divstep_unit_tb.sv
module divstep_unit_tb;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cmd_valid = 1'b0;
  logic [1:0]   cmd = 2'b00;
  logic [W-1:0] wr_rem = '0;
  logic         wr_t = 1'b0;
  logic [W-1:0] divisor = '0;
  logic [W-1:0] rem_q;
  logic         q_flag, m_flag, t_flag;

  int total = 0;
  int bad = 0;

  logic [W-1:0] e_rem;
  logic         e_q, e_m, e_t;

  always #5 clk = ~clk;

  divstep_unit #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd(cmd),
    .wr_rem(wr_rem), .wr_t(wr_t), .divisor(divisor),
    .rem_q(rem_q), .q_flag(q_flag), .m_flag(m_flag), .t_flag(t_flag)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model(input logic [1:0] c, input logic [W-1:0] wv, input logic wt,
                       input logic [W-1:0] dv);
    logic [W-1:0] sh, res;
    logic cb, nq;
    case (c)
      2'b00: begin e_rem = wv; e_t = wt; end
      2'b01: begin e_q = 0; e_m = 0; e_t = 0; end
      2'b10: begin e_q = e_rem[W-1]; e_m = dv[W-1]; e_t = e_rem[W-1] ^ dv[W-1]; end
      default: begin
        sh = {e_rem[W-2:0], e_t};
        if (e_q == e_m) begin res = sh - dv; cb = (res > sh); end
        else begin res = sh + dv; cb = (res < sh); end
        nq = e_rem[W-1] ^ e_m ^ cb;
        e_rem = res; e_q = nq; e_t = (nq == e_m);
      end
    endcase
  endtask

  task automatic issue(input logic [1:0] c, input logic [W-1:0] wv, input logic wt,
                       input logic [W-1:0] dv);
    @(negedge clk);
    cmd_valid = 1'b1; cmd = c; wr_rem = wv; wr_t = wt; divisor = dv;
    @(negedge clk);
    cmd_valid = 1'b0;
    model(c, wv, wt, dv);
  endtask

  task automatic check_all(input logic [1:0] c);
    case (c)
      2'b00: begin
        check("R1 rem", rem_q, e_rem); check("R1 t", {31'b0, t_flag}, {31'b0, e_t});
        check("R1 qm", {30'b0, q_flag, m_flag}, {30'b0, e_q, e_m});
      end
      2'b01: begin
        check("R2 flags", {29'b0, q_flag, m_flag, t_flag}, {29'b0, e_q, e_m, e_t});
        check("R2 rem", rem_q, e_rem);
      end
      2'b10: begin
        check("R3 flags", {29'b0, q_flag, m_flag, t_flag}, {29'b0, e_q, e_m, e_t});
        check("R3 rem", rem_q, e_rem);
      end
      default: begin
        check("R4 rem", rem_q, e_rem);
        check("R5 q", {31'b0, q_flag}, {31'b0, e_q});
        check("R5 m", {31'b0, m_flag}, {31'b0, e_m});
        check("R6 t", {31'b0, t_flag}, {31'b0, e_t});
      end
    endcase
  endtask

  task automatic udiv(input logic [W-1:0] dd, input logic [W-1:0] dv);
    logic [W-1:0] word;
    logic nt;
    word = dd;
    issue(2'b00, '0, 1'b0, dv);
    issue(2'b01, '0, 1'b0, dv);
    for (int i = 0; i < W; i++) begin
      nt = word[W-1];
      word = {word[W-2:0], t_flag};
      issue(2'b00, rem_q, nt, dv);
      issue(2'b11, '0, 1'b0, dv);
    end
    word = {word[W-2:0], t_flag};
    check("R9 quotient", word, dd / dv);
  endtask

  initial begin
    #2000000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [W-1:0] dvals [4];
    void'($urandom(32'h5eed));
    e_rem = '0; e_q = 0; e_m = 0; e_t = 0;
    repeat (3) @(negedge clk);
    check("R8 rem", rem_q, '0);
    check("R8 flags", {29'b0, q_flag, m_flag, t_flag}, 32'h0);
    rst_n = 1'b1;

    dvals[0] = '0; dvals[1] = 32'h1; dvals[2] = '1; dvals[3] = 32'h8000_0000;
    for (int i = 0; i < 4; i++) begin
      issue(2'b00, 32'hC000_0001, 1'b1, dvals[i]); check_all(2'b00);
      issue(2'b10, '0, 1'b0, dvals[i]);            check_all(2'b10);
      issue(2'b11, '0, 1'b0, dvals[i]);            check_all(2'b11);
      issue(2'b11, '0, 1'b0, dvals[i]);            check_all(2'b11);
      issue(2'b01, '0, 1'b0, dvals[i]);            check_all(2'b01);
      issue(2'b11, '0, 1'b0, dvals[i]);            check_all(2'b11);
    end

    for (int n = 0; n < 400; n++) begin
      logic [1:0] c;
      c = 2'($urandom);
      if ($urandom % 5 == 0) begin
        @(negedge clk);
        cmd = c; wr_rem = $urandom; wr_t = 1'($urandom); divisor = $urandom;
        @(negedge clk);
        check("R7 rem", rem_q, e_rem);
        check("R7 flags", {29'b0, q_flag, m_flag, t_flag}, {29'b0, e_q, e_m, e_t});
      end else begin
        issue(c, $urandom, 1'($urandom), ($urandom % 3 == 0) ? {$urandom} | 32'h8000_0000 : $urandom);
        check_all(c);
      end
    end

    udiv(32'd1, 32'd1);
    udiv(32'd100, 32'd7);
    udiv(32'hFFFF_FFFF, 32'd1);
    udiv(32'hFFFF_FFFF, 32'hFFFF_FFFF);
    udiv(32'h1234_5678, 32'h8000_0001);
    udiv(32'd5, 32'd9);
    for (int n = 0; n < 40; n++) begin
      logic [W-1:0] a, b;
      a = $urandom;
      b = $urandom >> ($urandom % 32);
      if (b == 0) b = 32'd3;
      udiv(a, b);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule